// File: doc/BRIEF.md
# Packed Palette Write Sequencer

This block is the host-side write path of a 256-entry RGB colour lookup table, together with the pixel-side lookup that reads it. A 32-bit host word carries colour components one byte each. The block feeds them through a red, green, blue cycle, keeps the first two components of an entry in holding registers, and writes the whole 24-bit entry into palette RAM when its blue component arrives. After each commit the entry pointer moves on by itself, so host words do not need to line up with entry boundaries. In wide mode all four bytes of a word are components, taken from the most significant byte down. In narrow mode only the top byte counts.

The host port uses valid/ready. A word moves when `host_valid` and `host_ready` are both high on a rising edge. The host must hold `host_valid`, `host_sel`, `host_data` and `wide_mode` steady until then. `host_ready` does not depend on `host_valid`. It falls after a colour-data word is taken and stays low while that word's components are consumed, one per cycle. Every kind of host write waits for this, so writes always take effect in the order they were issued.

`host_sel` picks one of four targets:
- an address register, which sets the entry pointer and also selects an indirect control register;
- a colour-data port;
- a control port, which writes the indirect register the address register selects;
- an overlay port, which fills a small four-entry overlay palette kept apart from the main map.

A pixel lookup applies a plane mask to the index and returns the registered colour on the next clock. The pixel port has no back-pressure.

Top module: `palette_wr_seq`

## Requirements
- R1: After reset `host_ready` is 1, `pix_out_valid` is 0, `pix_rgb` is 0, `cmd_reg` is 0x00, the plane mask is 0xFF, and all overlay entries are 0.
- R2: Components of a palette entry arrive in the order red, green, blue. The entry is written to RAM only when blue arrives, and it reads back as `pix_rgb[23:16]`=red, `[15:8]`=green, `[7:0]`=blue.
- R3: With `wide_mode`=1, a colour-data write (`host_sel`=1) yields four components, in the order `host_data[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. One word can finish one entry and begin the next.
- R4: With `wide_mode`=0, a colour-data write yields only `host_data[31:24]` as one component, and the other bytes are ignored.
- R5: After each committed entry the pointer advances by one, and it wraps from 255 to 0.
- R6: An address write (`host_sel`=0) sets the entry pointer and restarts the sequence at red. Partly written entries are dropped and leave the RAM unchanged.
- R7: `host_ready` stays low while an accepted colour-data word still has components left: four cycles for a wide word and one cycle for a narrow word. A word presented while `host_ready` is low is not taken.
- R8: A control write (`host_sel`=2) updates the indirect register whose index is the address register value: 0x06 is the command register (`cmd_reg`) and 0x04 is the plane mask. Any other index is ignored. For address, control and overlay writes the byte used is `host_data[7:0]` when `wide_mode`=1 and `host_data[31:24]` when `wide_mode`=0.
- R9: The pixel index is ANDed with the plane mask before the lookup. A mask of 0x00 sends every pixel to entry 0.
- R10: A lookup issued with `pix_valid` is returned on `pix_rgb` with `pix_out_valid`=1 one cycle later, and `pix_rgb` holds its value when there is no lookup. A lookup in the same cycle as a commit to the same entry returns the entry's previous contents.
- R11: An overlay write (`host_sel`=3) gives one component, which runs through its own red/green/blue sequence. On blue it commits to the overlay entry, whose index is set by the low two bits of an address write, and the overlay index then advances, wrapping after entry 3. With `pix_ovl_en`=1 a lookup returns overlay entry `pix_ovl_index`, and the plane mask is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: all bytes of a data word are used; 0: top byte only |
| host_valid | input | 1 | Host word present |
| host_ready | output | 1 | Block can take a host word |
| host_sel | input | 2 | 0 address, 1 colour data, 2 control, 3 overlay |
| host_data | input | 32 | Host word |
| pix_valid | input | 1 | Pixel lookup request |
| pix_index | input | 8 | Pixel colour index |
| pix_ovl_en | input | 1 | Look up the overlay palette instead |
| pix_ovl_index | input | 2 | Overlay entry index |
| pix_out_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Looked-up colour |
| cmd_reg | output | 8 | Command register contents |

## Verification
A commit of a finished entry into palette RAM can land on the same clock edge as a pixel lookup of that same entry. The bench sets this up by writing the red and green components first. It then times a narrow blue write so that its component is consumed on the edge where a lookup of that index is sampled. It expects the old contents on that cycle and the new colour from a lookup one cycle later. The bench also overlaps wide words that straddle entries with pointer wrap and with mid-entry address writes, and it judges each case only through lookups.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  // host target encoding on host_sel
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CMAP = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_OVL  = 2'd3
  } host_sel_e;

  // colour component phase within an entry
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } comp_ph_e;
endpackage

// File: rtl/pal_unpack.sv
`timescale 1ns/1ps
// Serialises an accepted host word into byte components, MSB first.
module pal_unpack #(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HOST_W-1:0] in_word,
  input  logic              in_wide,
  output logic              comp_valid,
  output logic [CW-1:0]     comp_byte
);
  localparam int unsigned BYTES = HOST_W / CW;
  localparam int unsigned CNT_W = $clog2(BYTES + 1);

  logic [HOST_W-1:0] buf_q;
  logic [CNT_W-1:0]  left_q;

  assign in_ready   = (left_q == '0);
  assign comp_valid = (left_q != '0);
  assign comp_byte  = buf_q[HOST_W-1 -: CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
    end else if (in_valid && in_ready) begin
      buf_q  <= in_word;
      left_q <= in_wide ? CNT_W'(BYTES) : CNT_W'(1);
    end else if (left_q != '0) begin
      buf_q  <= buf_q << CW;
      left_q <= left_q - CNT_W'(1);
    end
  end

  // R3
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (comp_valid && comp_byte == $past(in_word[HOST_W-1 -: CW])));
  // R7
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_wide) |=> !in_ready);
endmodule

// File: rtl/pal_seq.sv
`timescale 1ns/1ps
// Red/green/blue component sequencer with holding registers and auto-advancing pointer.
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          comp_valid,
  input  logic [CW-1:0] comp_byte,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_val,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [3*CW-1:0] wr_rgb
);
  comp_ph_e      ph_q;
  logic [CW-1:0] red_q, grn_q;
  logic [AW-1:0] ptr_q;

  assign wr_en  = comp_valid && (ph_q == PH_BLU);
  assign wr_idx = ptr_q;
  assign wr_rgb = {red_q, grn_q, comp_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RED;
      red_q <= '0;
      grn_q <= '0;
      ptr_q <= '0;
    end else if (addr_wr) begin
      ptr_q <= addr_val;
      ph_q  <= PH_RED;
    end else if (comp_valid) begin
      case (ph_q)
        PH_RED: begin red_q <= comp_byte; ph_q <= PH_GRN; end
        PH_GRN: begin grn_q <= comp_byte; ph_q <= PH_BLU; end
        default: begin ph_q <= PH_RED; ptr_q <= ptr_q + AW'(1); end
      endcase
    end
  end

  // R2
  no_back_to_back_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_idx == AW'($past(wr_idx) + AW'(1))));
  // R6
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (wr_idx == $past(addr_val)));
  // R7
  always_comb begin
    addr_vs_comp_chk: assert (!(rst_n && addr_wr && comp_valid));
  end
endmodule

// File: rtl/pal_ctrl.sv
`timescale 1ns/1ps
// Indirect control registers: command and plane mask.
module pal_ctrl #(
  parameter int unsigned CW       = 8,
  parameter int unsigned CMD_IDX  = 6,
  parameter int unsigned MASK_IDX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] sel_idx,
  input  logic [CW-1:0] ctrl_val,
  output logic [CW-1:0] cmd_q,
  output logic [CW-1:0] mask_q
);
  logic hit_cmd, hit_mask;
  assign hit_cmd  = (sel_idx == CW'(CMD_IDX));
  assign hit_mask = (sel_idx == CW'(MASK_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '1;
    end else if (ctrl_wr) begin
      if (hit_cmd)  cmd_q  <= ctrl_val;
      if (hit_mask) mask_q <= ctrl_val;
    end
  end

  // R8
  other_idx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !hit_cmd && !hit_mask) |=> ($stable(cmd_q) && $stable(mask_q)));
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && hit_mask) |=> (mask_q == $past(ctrl_val)));
endmodule

// File: rtl/pal_lookup.sv
`timescale 1ns/1ps
// Palette RAM, overlay palette and registered masked pixel lookup.
module pal_lookup #(
  parameter int unsigned CW     = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned OVL_AW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_we,
  input  logic [AW-1:0]   main_widx,
  input  logic [3*CW-1:0] main_wdata,
  input  logic            ovl_we,
  input  logic [OVL_AW-1:0] ovl_widx,
  input  logic [3*CW-1:0] ovl_wdata,
  input  logic [CW-1:0]   plane_mask,
  input  logic            pix_valid,
  input  logic [AW-1:0]   pix_index,
  input  logic            pix_ovl_en,
  input  logic [OVL_AW-1:0] pix_ovl_index,
  output logic            out_valid,
  output logic [3*CW-1:0] out_rgb
);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam int unsigned OVL_N  = 1 << OVL_AW;

  logic [3*CW-1:0] mem [DEPTH];
  logic [3*CW-1:0] ovl_mem [OVL_N];
  logic [AW-1:0]   eff_idx;

  assign eff_idx = pix_index & AW'(plane_mask);

  always_ff @(posedge clk) begin
    if (main_we) mem[main_widx] <= main_wdata;
  end

  for (genvar g = 0; g < OVL_N; g++) begin : g_ovl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ovl_mem[g] <= '0;
      else if (ovl_we && ovl_widx == OVL_AW'(g))    ovl_mem[g] <= ovl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_rgb <= pix_ovl_en ? ovl_mem[pix_ovl_index] : mem[eff_idx];
    end
  end

  // R10
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(out_rgb) && !out_valid));
endmodule

// File: rtl/palette_wr_seq.sv
`timescale 1ns/1ps
// Top: host valid/ready write path into a packed RGB palette plus pixel lookup.
module palette_wr_seq
  import pal_pkg::*;
#(
  parameter int unsigned HOST_W   = 32,
  parameter int unsigned CW       = 8,
  parameter int unsigned AW       = 8,
  parameter int unsigned OVL_AW   = 2,
  parameter int unsigned CMD_IDX  = 6,
  parameter int unsigned MASK_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_data,
  input  logic              pix_valid,
  input  logic [AW-1:0]     pix_index,
  input  logic              pix_ovl_en,
  input  logic [OVL_AW-1:0] pix_ovl_index,
  output logic              pix_out_valid,
  output logic [3*CW-1:0]   pix_rgb,
  output logic [CW-1:0]     cmd_reg
);
  host_sel_e        sel;
  logic             unp_ready, accept;
  logic             comp_valid;
  logic [CW-1:0]    comp_byte, reg_byte, addr_q, mask;
  logic             addr_wr, ctrl_wr, ovl_comp;
  logic             main_we, ovl_we;
  logic [AW-1:0]    main_widx;
  logic [OVL_AW-1:0] ovl_widx;
  logic [3*CW-1:0]  main_wdata, ovl_wdata;

  assign sel        = host_sel_e'(host_sel);
  assign host_ready = unp_ready;
  assign accept     = host_valid && host_ready;
  assign reg_byte   = wide_mode ? host_data[CW-1:0] : host_data[HOST_W-1 -: CW];
  assign addr_wr    = accept && (sel == SEL_ADDR);
  assign ctrl_wr    = accept && (sel == SEL_CTRL);
  assign ovl_comp   = accept && (sel == SEL_OVL);

  // address register doubles as the indirect control selector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_wr) addr_q <= reg_byte;
  end

  pal_unpack #(.HOST_W(HOST_W), .CW(CW)) u_unpack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(host_valid && (sel == SEL_CMAP)), .in_ready(unp_ready),
    .in_word(host_data), .in_wide(wide_mode),
    .comp_valid(comp_valid), .comp_byte(comp_byte)
  );

  pal_seq #(.CW(CW), .AW(AW)) u_main_seq (
    .clk(clk), .rst_n(rst_n),
    .comp_valid(comp_valid), .comp_byte(comp_byte),
    .addr_wr(addr_wr), .addr_val(AW'(reg_byte)),
    .wr_en(main_we), .wr_idx(main_widx), .wr_rgb(main_wdata)
  );

  pal_seq #(.CW(CW), .AW(OVL_AW)) u_ovl_seq (
    .clk(clk), .rst_n(rst_n),
    .comp_valid(ovl_comp), .comp_byte(reg_byte),
    .addr_wr(addr_wr), .addr_val(OVL_AW'(reg_byte)),
    .wr_en(ovl_we), .wr_idx(ovl_widx), .wr_rgb(ovl_wdata)
  );

  pal_ctrl #(.CW(CW), .CMD_IDX(CMD_IDX), .MASK_IDX(MASK_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .sel_idx(addr_q), .ctrl_val(reg_byte),
    .cmd_q(cmd_reg), .mask_q(mask)
  );

  pal_lookup #(.CW(CW), .AW(AW), .OVL_AW(OVL_AW)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .main_we(main_we), .main_widx(main_widx), .main_wdata(main_wdata),
    .ovl_we(ovl_we), .ovl_widx(ovl_widx), .ovl_wdata(ovl_wdata),
    .plane_mask(mask),
    .pix_valid(pix_valid), .pix_index(pix_index),
    .pix_ovl_en(pix_ovl_en), .pix_ovl_index(pix_ovl_index),
    .out_valid(pix_out_valid), .out_rgb(pix_rgb)
  );

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == SEL_CMAP) |=> !host_ready);
endmodule

// File: tb/palette_wr_seq_bench.sv
`timescale 1ns/1ps
module palette_wr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_data = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_index = '0;
  logic        pix_ovl_en = 1'b0;
  logic [1:0]  pix_ovl_index = '0;
  logic        pix_out_valid;
  logic [23:0] pix_rgb;
  logic [7:0]  cmd_reg;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  palette_wr_seq u_palette_wr_seq (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_sel(host_sel), .host_data(host_data),
    .pix_valid(pix_valid), .pix_index(pix_index),
    .pix_ovl_en(pix_ovl_en), .pix_ovl_index(pix_ovl_index),
    .pix_out_valid(pix_out_valid), .pix_rgb(pix_rgb), .cmd_reg(cmd_reg)
  );

  // row: kind(2) 0=write 1=main lookup 2=overlay lookup | wide(1) | sel(2) | data(32) | exp(24) | req(4)
  localparam int NROW = 44;
  localparam logic [64:0] TBL [NROW] = '{
    {2'd0,1'b1,2'd0,32'h00000000,24'h000000,4'd6},  // R6 pointer to 0
    {2'd0,1'b1,2'd1,32'h11223344,24'h000000,4'd3},  // R3 R0 G0 B0 R1
    {2'd0,1'b1,2'd1,32'h55667788,24'h000000,4'd3},  // R3 G1 B1 R2 G2
    {2'd1,1'b0,2'd0,32'h00000000,24'h112233,4'd2},  // R2 order
    {2'd1,1'b0,2'd0,32'h00000001,24'h445566,4'd3},  // R3 straddle
    {2'd0,1'b0,2'd1,32'h99AABBCC,24'h000000,4'd4},  // R4 narrow: B2 only
    {2'd1,1'b0,2'd0,32'h00000002,24'h778899,4'd4},
    {2'd0,1'b1,2'd0,32'h000000FF,24'h000000,4'd6},
    {2'd0,1'b1,2'd1,32'h0A0B0C0D,24'h000000,4'd5},  // R5 wrap 255->0
    {2'd1,1'b0,2'd0,32'h000000FF,24'h0A0B0C,4'd1},  // R1 reset mask all ones
    {2'd0,1'b1,2'd1,32'hE0F01213,24'h000000,4'd5},
    {2'd1,1'b0,2'd0,32'h00000000,24'h0DE0F0,4'd5},
    {2'd1,1'b0,2'd0,32'h00000001,24'h445566,4'd6},  // R6 partial leaves RAM
    {2'd0,1'b1,2'd0,32'h00000001,24'h000000,4'd6},
    {2'd0,1'b1,2'd1,32'h21222324,24'h000000,4'd6},
    {2'd1,1'b0,2'd0,32'h00000001,24'h212223,4'd6},  // R6 restart at red
    {2'd1,1'b0,2'd0,32'h00000002,24'h778899,4'd6},
    {2'd0,1'b0,2'd0,32'h04000000,24'h000000,4'd8},  // R8 narrow select mask
    {2'd0,1'b0,2'd2,32'h01000000,24'h000000,4'd8},
    {2'd1,1'b0,2'd0,32'h000000FF,24'h212223,4'd9},  // R9 mask 0x01
    {2'd1,1'b0,2'd0,32'h00000002,24'h0DE0F0,4'd9},
    {2'd0,1'b1,2'd0,32'h00000005,24'h000000,4'd8},
    {2'd0,1'b1,2'd2,32'h00000000,24'h000000,4'd8},  // R8 index 5 ignored
    {2'd1,1'b0,2'd0,32'h000000FF,24'h212223,4'd8},
    {2'd0,1'b1,2'd0,32'h00000004,24'h000000,4'd9},
    {2'd0,1'b1,2'd2,32'h00000000,24'h000000,4'd9},  // R9 blanking mask
    {2'd1,1'b0,2'd0,32'h000000FF,24'h0DE0F0,4'd9},
    {2'd1,1'b0,2'd0,32'h00000001,24'h0DE0F0,4'd9},
    {2'd0,1'b1,2'd2,32'h000000FF,24'h000000,4'd9},
    {2'd1,1'b0,2'd0,32'h00000001,24'h212223,4'd9},
    {2'd0,1'b1,2'd0,32'h00000002,24'h000000,4'd11}, // R11 overlay index 2
    {2'd0,1'b1,2'd3,32'h000000A1,24'h000000,4'd11},
    {2'd0,1'b1,2'd3,32'h000000A2,24'h000000,4'd11},
    {2'd0,1'b1,2'd3,32'h000000A3,24'h000000,4'd11},
    {2'd2,1'b0,2'd0,32'h00000002,24'hA1A2A3,4'd11},
    {2'd2,1'b0,2'd0,32'h00000003,24'h000000,4'd11},
    {2'd0,1'b0,2'd3,32'hC1FFFFFF,24'h000000,4'd11},
    {2'd0,1'b0,2'd3,32'hC2FFFFFF,24'h000000,4'd11},
    {2'd0,1'b0,2'd3,32'hC3FFFFFF,24'h000000,4'd11},
    {2'd2,1'b0,2'd0,32'h00000003,24'hC1C2C3,4'd11},
    {2'd0,1'b0,2'd3,32'hD1000000,24'h000000,4'd11},
    {2'd0,1'b0,2'd3,32'hD2000000,24'h000000,4'd11},
    {2'd0,1'b0,2'd3,32'hD3000000,24'h000000,4'd11},
    {2'd2,1'b0,2'd0,32'h00000000,24'hD1D2D3,4'd11}  // R11 overlay wrap
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic w, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wide_mode = w; host_sel = s; host_data = d; host_valid = 1'b1;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    while (!host_ready) @(negedge clk);
  endtask

  task automatic lookup(input logic ov, input logic [7:0] idx, output logic [23:0] res);
    @(negedge clk);
    pix_valid = 1'b1; pix_ovl_en = ov; pix_index = idx; pix_ovl_index = idx[1:0];
    @(negedge clk);
    pix_valid = 1'b0; pix_ovl_en = 1'b0;
    res = pix_rgb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] got;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "ready after reset", {31'd0, host_ready}, 32'd1);
    chk(1, "out_valid after reset", {31'd0, pix_out_valid}, 32'd0);
    chk(1, "rgb after reset", {8'd0, pix_rgb}, 32'd0);
    chk(1, "cmd after reset", {24'd0, cmd_reg}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      logic [64:0] row;
      row = TBL[i];
      if (row[64:63] == 2'd0) begin
        host_write(row[62], row[61:60], row[59:28]);
      end else begin
        lookup(row[64:63] == 2'd2, row[35:28], got);
        chk(int'(row[3:0]), $sformatf("table row %0d", i), {8'd0, got}, {8'd0, row[27:4]});
      end
    end

    // R8 command register through index 0x06
    host_write(1'b1, 2'd0, 32'h00000006);
    host_write(1'b1, 2'd2, 32'h00000073);
    chk(8, "command register", {24'd0, cmd_reg}, 32'h73);

    // R7 back-pressure length, wide word
    @(negedge clk);
    wide_mode = 1'b1; host_sel = 2'd1; host_data = 32'h01020304; host_valid = 1'b1;
    @(negedge clk);
    host_valid = 1'b0; n = 0;
    while (!host_ready) begin n++; @(negedge clk); end
    chk(7, "wide ready-low cycles", n, 4);
    // R7 back-pressure length, narrow word
    @(negedge clk);
    wide_mode = 1'b0; host_sel = 2'd1; host_data = 32'h05000000; host_valid = 1'b1;
    @(negedge clk);
    host_valid = 1'b0; n = 0;
    while (!host_ready) begin n++; @(negedge clk); end
    chk(7, "narrow ready-low cycles", n, 1);

    // R10 lookup colliding with a commit to the same entry
    host_write(1'b1, 2'd0, 32'h00000010);
    host_write(1'b1, 2'd1, 32'h01020304);
    host_write(1'b1, 2'd0, 32'h00000010);
    host_write(1'b0, 2'd1, 32'h31000000);
    host_write(1'b0, 2'd1, 32'h32000000);
    @(negedge clk);
    wide_mode = 1'b0; host_sel = 2'd1; host_data = 32'h33000000; host_valid = 1'b1;
    @(negedge clk);
    host_valid = 1'b0;
    pix_valid = 1'b1; pix_index = 8'h10; pix_ovl_en = 1'b0;
    @(negedge clk);
    pix_valid = 1'b0;
    chk(10, "collision out_valid", {31'd0, pix_out_valid}, 32'd1);
    chk(10, "collision returns old", {8'd0, pix_rgb}, 32'h010203);
    @(negedge clk);
    chk(10, "out_valid drops", {31'd0, pix_out_valid}, 32'd0);
    chk(10, "rgb held when idle", {8'd0, pix_rgb}, 32'h010203);
    lookup(1'b0, 8'h10, got);
    chk(2, "entry after blue", {8'd0, got}, 32'h313233);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule